// File: doc/BRIEF.md
# Prescaled Periodic Interval Timer

This block produces a periodic interrupt from a down-counter that is slowed by a programmable prescaler. Software programs three registers through a small register port: an 8-bit scale value, a 16-bit live count and a 16-bit reload period. While the enable input is high, the prescaler expires once every n clock cycles, where n is the scale value. Each expiry is a tick, and each tick decrements the count.

When a tick arrives while the count is already zero, the block pulses its interrupt output for one cycle and reloads the count from the period register. This repeats for as long as the block stays enabled. The interrupt interval is therefore n × (period + 1) cycles. Reads are combinational, so the live count can be polled at any time.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset, the scale, count and period registers all read zero and `irq` is low.
- R2: While `en` is high, the count decreases by one on every tick. A tick happens once every n enabled cycles, with n equal to the scale value (1 to 255).
- R3: A scale value of zero behaves exactly like a scale value of one, so the count moves on every enabled cycle.
- R4: A tick that finds the count at zero reloads the count from the period register. The same tick makes `irq` high for exactly the following cycle. With the count started at P and the period set to P, interrupts arrive every n × (P + 1) enabled cycles.
- R5: While `en` is low, the count and the prescaler both hold their values and `irq` stays low. Counting resumes from the same prescaler phase when `en` returns high.
- R6: A count write in a cycle that would also tick wins. The count takes the written value, no decrement or reload happens, and no interrupt is raised by that tick.
- R7: A scale write restarts the prescaler from the new value, so the next tick comes n enabled cycles after the write. A tick due in the same cycle as the write is dropped.
- R8: Register map on `reg_addr`: 0 selects scale (bits 7:0 hold the value, upper read bits are zero), 1 selects count, 2 selects period, and 3 reads zero and ignores writes. `rd_data` follows `reg_addr` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Count enable; low freezes the timer |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select for write and read |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Read data of the selected register |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench sweeps several scale and period pairs, including the largest scale, and counts pulses against the n × (P + 1) interval. An off-by-one in either the prescaler or the reload would shift that count. It checks that a zero scale does not stall the timer and that a disabled timer keeps its prescaler phase; a design that let the prescaler run while disabled would tick early after re-enable. It also writes the count and the scale in cycles that would tick. A design that let the decrement win, or that kept the old prescaler phase, would show a count off by one, or an interrupt that should not appear.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int CNT_W  = 16;
    localparam int SCL_W  = 8;
    localparam int ADDR_W = 2;

    typedef enum logic [ADDR_W-1:0] {
        SEL_SCALE  = 2'd0,
        SEL_COUNT  = 2'd1,
        SEL_PERIOD = 2'd2,
        SEL_SPARE  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic scale;
        logic count;
        logic period;
    } wr_strb_t;

    // effective prescale divisor: zero acts as one
    function automatic logic [SCL_W-1:0] eff_scale(input logic [SCL_W-1:0] s);
        return (s == '0) ? SCL_W'(1) : s;
    endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs #(
    parameter int CNT_W = tmr_pkg::CNT_W,
    parameter int SCL_W = tmr_pkg::SCL_W
) (
    input  logic               clk,
    input  logic               rst,
    input  tmr_pkg::wr_strb_t  strb,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [SCL_W-1:0]   scale_q,
    output logic [CNT_W-1:0]   per_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            scale_q <= '0;
            per_q   <= '0;
        end else begin
            if (strb.scale)  scale_q <= wr_data[SCL_W-1:0];
            if (strb.period) per_q   <= wr_data;
        end
    end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale #(
    parameter int SCL_W = tmr_pkg::SCL_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             scale_wr,
    input  logic [SCL_W-1:0] scale_new,
    input  logic [SCL_W-1:0] scale_q,
    output logic [SCL_W-1:0] pre_q,
    output logic             tick
);
    localparam logic [SCL_W-1:0] ONE = SCL_W'(1);

    // a scale write drops any tick due in the same cycle
    assign tick = en && !scale_wr && (pre_q == ONE);

    always_ff @(posedge clk) begin
        if (rst)
            pre_q <= ONE;
        else if (scale_wr)
            pre_q <= tmr_pkg::eff_scale(scale_new);
        else if (en) begin
            if (pre_q == ONE) pre_q <= tmr_pkg::eff_scale(scale_q);
            else              pre_q <= pre_q - ONE;
        end
    end
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = tmr_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [CNT_W-1:0] per_q,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (cnt_wr)
                cnt_q <= wr_data;
            else if (tick) begin
                if (cnt_q == '0) begin
                    cnt_q <= per_q;
                    irq   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - CNT_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/tick_timer.sv
module tick_timer #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int SCL_W  = tmr_pkg::SCL_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  wr_data,
    output logic [CNT_W-1:0]  rd_data,
    output logic              irq
);
    import tmr_pkg::*;

    localparam int PAD_W = CNT_W - SCL_W;

    reg_sel_e         sel;
    wr_strb_t         strb;
    logic [SCL_W-1:0] scale_q;
    logic [SCL_W-1:0] pre_q;
    logic [CNT_W-1:0] per_q;
    logic [CNT_W-1:0] cnt_q;
    logic             tick;

    assign sel = reg_sel_e'(reg_addr);

    always_comb begin
        strb        = '0;
        strb.scale  = wr_en && (sel == SEL_SCALE);
        strb.count  = wr_en && (sel == SEL_COUNT);
        strb.period = wr_en && (sel == SEL_PERIOD);
    end

    tmr_regs #(.CNT_W(CNT_W), .SCL_W(SCL_W)) u_regs (
        .clk(clk), .rst(rst), .strb(strb), .wr_data(wr_data),
        .scale_q(scale_q), .per_q(per_q)
    );

    tmr_prescale #(.SCL_W(SCL_W)) u_pre (
        .clk(clk), .rst(rst), .en(en), .scale_wr(strb.scale),
        .scale_new(wr_data[SCL_W-1:0]), .scale_q(scale_q),
        .pre_q(pre_q), .tick(tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst(rst), .tick(tick), .cnt_wr(strb.count),
        .wr_data(wr_data), .per_q(per_q), .cnt_q(cnt_q), .irq(irq)
    );

    always_comb begin
        unique case (sel)
            SEL_SCALE:  rd_data = {{PAD_W{1'b0}}, scale_q};
            SEL_COUNT:  rd_data = cnt_q;
            SEL_PERIOD: rd_data = per_q;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk #(
    parameter int CNT_W  = tmr_pkg::CNT_W,
    parameter int SCL_W  = tmr_pkg::SCL_W,
    parameter int ADDR_W = tmr_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic              wr_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  per,
    input logic [SCL_W-1:0]  pre
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
    localparam logic [SCL_W-1:0] PONE = SCL_W'(1);

    logic cnt_wr, scl_wr;
    assign cnt_wr = wr_en && (reg_addr == ADDR_W'(1));
    assign scl_wr = wr_en && (reg_addr == ADDR_W'(0));

    p_dec_r2: assert property (@(posedge clk) disable iff (rst)
        (en && pre == PONE && !scl_wr && !cnt_wr && cnt != '0) |=> cnt == $past(cnt) - ONE);

    p_pre_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
        pre != '0);

    p_reload_r4: assert property (@(posedge clk) disable iff (rst)
        irq |-> (cnt == $past(per)) && ($past(cnt) == '0));

    p_freeze_r5: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr_en) |=> $stable(cnt) && $stable(pre) && !irq);

    p_cnt_wr_r6: assert property (@(posedge clk) disable iff (rst)
        cnt_wr |=> (cnt == $past(wr_data)) && !irq);

    p_scale_wr_r7: assert property (@(posedge clk) disable iff (rst)
        scl_wr |=> pre == tmr_pkg::eff_scale($past(wr_data[SCL_W-1:0])));
endmodule

bind tick_timer tick_timer_chk #(.CNT_W(CNT_W), .SCL_W(SCL_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .irq(irq), .cnt(cnt_q), .per(per_q), .pre(pre_q)
);

// File: tb/sim_tick_timer.sv
module sim_tick_timer;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 6;
    localparam int V_SC [NVEC] = '{1, 0, 3, 5, 255, 2};
    localparam int V_PER[NVEC] = '{0, 3, 2, 0, 1, 9};
    localparam int V_CYC[NVEC] = '{20, 40, 50, 23, 1100, 100};

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        irq;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;

    tick_timer u0 (
        .clk(clk), .rst(rst), .en(en), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // called just after an edge; returns just after the next edge
    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        wr_en = 1'b1; reg_addr = a; wr_data = d;
        @(posedge clk); #1;
        if (irq) irq_seen++;
        wr_en = 1'b0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            if (irq) irq_seen++;
        end
    endtask

    function automatic int rd(input logic [1:0] a);
        reg_addr = a;
        return 0;
    endfunction

    task automatic rdchk(input string req, input logic [1:0] a, input int exp);
        int dummy;
        dummy = rd(a);
        #1;
        chk(req, int'(rd_data), exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1 reset state
        chk("R1 irq", int'(irq), 0);
        rdchk("R1 scale", 2'd0, 0);
        rdchk("R1 count", 2'd1, 0);
        rdchk("R1 period", 2'd2, 0);

        // table of scale/period/run length against expected pulse count (R2 R3 R4)
        for (int v = 0; v < NVEC; v++) begin
            int n;
            n = (V_SC[v] == 0) ? 1 : V_SC[v];
            wr(2'd0, 16'(V_SC[v]));
            wr(2'd2, 16'(V_PER[v]));
            wr(2'd1, 16'(V_PER[v]));
            irq_seen = 0;
            en = 1'b1;
            step(V_CYC[v]);
            en = 1'b0;
            chk("R4 R2 R3 pulse count", irq_seen, V_CYC[v] / (n * (V_PER[v] + 1)));
        end

        // R3 scale zero moves every cycle
        wr(2'd0, 16'd0); wr(2'd1, 16'd3);
        en = 1'b1; step(1); en = 1'b0;
        rdchk("R3 zero scale", 2'd1, 2);

        // R2 scale 4 decrements after 4 cycles, not 3
        wr(2'd0, 16'd4); wr(2'd1, 16'd10);
        en = 1'b1; step(3);
        // R7 rewrite scale where a tick was due
        wr(2'd0, 16'd4); en = 1'b0;
        rdchk("R7 dropped tick", 2'd1, 10);
        en = 1'b1; step(3); en = 1'b0;
        rdchk("R7 restart phase", 2'd1, 10);
        en = 1'b1; step(1); en = 1'b0;
        rdchk("R2 tick after n", 2'd1, 9);

        // R5 freeze keeps prescaler phase
        wr(2'd0, 16'd3); wr(2'd1, 16'd20);
        en = 1'b1; step(2); en = 1'b0;
        irq_seen = 0;
        step(30);
        rdchk("R5 count frozen", 2'd1, 20);
        chk("R5 no irq", irq_seen, 0);
        en = 1'b1; step(1); en = 1'b0;
        rdchk("R5 resume phase", 2'd1, 19);

        // R4 reload and single-cycle pulse
        wr(2'd0, 16'd1); wr(2'd2, 16'd7); wr(2'd1, 16'd2);
        en = 1'b1; step(2);
        chk("R4 no early irq", int'(irq), 0);
        step(1); en = 1'b0;
        chk("R4 irq pulse", int'(irq), 1);
        rdchk("R4 reload", 2'd1, 7);
        step(1);
        chk("R4 pulse one cycle", int'(irq), 0);

        // R6 count write beats decrement
        wr(2'd1, 16'd5);
        en = 1'b1; wr(2'd1, 16'd100); en = 1'b0;
        rdchk("R6 write over decrement", 2'd1, 100);
        // R6 count write beats reload and suppresses irq
        wr(2'd1, 16'd0);
        en = 1'b1; wr(2'd1, 16'd50); en = 1'b0;
        chk("R6 irq suppressed", int'(irq), 0);
        rdchk("R6 write over reload", 2'd1, 50);

        // R8 map: upper scale bits read zero, spare slot inert
        wr(2'd0, 16'hABCD);
        rdchk("R8 scale width", 2'd0, 16'h00CD);
        wr(2'd3, 16'hFFFF);
        rdchk("R8 spare reads zero", 2'd3, 0);
        rdchk("R8 spare scale", 2'd0, 16'h00CD);
        rdchk("R8 spare count", 2'd1, 50);
        rdchk("R8 spare period", 2'd2, 7);

        // R1 reset clears programmed state
        rst = 1'b1; step(1); rst = 1'b0;
        rdchk("R1 reset count", 2'd1, 0);
        rdchk("R1 reset period", 2'd2, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule